// File: doc/BRIEF.md
# I2C Master START Generator with Bus-Hang Recovery

This block is the START-issuing front end of an I2C master. A register write sets a start request and, optionally, a stop request. The block drives SCL and SDA as open-drain lines (an enable means "pull low"), reads both lines back through synchronizers, and keeps track of whether the bus is busy from the START and STOP conditions it observes. When the bus is free, or when the block already owns the bus (repeated START), it produces a START. It then holds SCL and SDA low and reports success with a status code and a one-cycle done pulse.

Two recovery paths need no processor help. A stop request written while a start request waits on a busy bus forces access. The block drives no STOP, treats the bus as free and clears the stop request itself. If a slave holds SDA low, the block clocks SCL with extra pulses and retries the START after every second pulse until SDA comes back high. An SCL line held low by another device cannot be fixed here, so the block only flags it. Byte transfer, arbitration and slave operation belong to neighbouring logic.

Top module: `i2c_start_ctrl`

## Requirements
- R1: After reset both line enables are off, `sta_o`, `sto_o`, `bus_busy_o`, `scl_stuck_o` and `done_o` are 0 and `status_o` is 8'hF8.
- R2: `bus_busy_o` goes to 1 after a START appears on the lines (SDA falls while SCL is high) and returns to 0 after a STOP (SDA rises while SCL is high).
- R3: On a free bus with SDA high, a start request produces a START. `sda_oe_o` rises while SCL is released and high, and SCL is pulled low afterwards. Then `done_o` pulses, `status_o` becomes 8'h08, `sta_o` clears, and both enables stay on.
- R4: While the bus is busy, not owned by this block, and no stop request is set, a pending start request drives neither line. The START follows once a STOP is seen.
- R5: A stop request set while a start request waits on a busy bus causes no STOP on the lines. The block clears `sto_o` by itself, treats the bus as free and issues the START.
- R6: If SDA is low when a START is about to be made, the block drives extra SCL pulses and checks SDA again after every second pulse. A slave that releases SDA after N falling SCL edges therefore sees 2*ceil(N/2) extra pulses before the START.
- R7: A start request while the block owns the bus releases SDA, then SCL, and then produces a repeated START. The SDA-low recovery of R6 applies to it and to a forced access alike.
- R8: If SCL stays low while the block waits for it to rise, `scl_stuck_o` rises after STUCK_HALVES half periods. SDA is not driven meanwhile, and the START proceeds once SCL is released.
- R9: A stop request with no start request pending drives neither line and leaves `sto_o` set.
- R10: Each extra SCL low phase lasts `half_i`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_i | input | HALF_W | Half SCL period in clock cycles, minus one (at least 2) |
| sta_set_i | input | 1 | One-cycle pulse that sets the start request |
| sto_set_i | input | 1 | One-cycle pulse that sets the stop request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sta_o | output | 1 | Start request pending |
| sto_o | output | 1 | Stop request pending |
| bus_busy_o | output | 1 | Bus seen as busy |
| scl_stuck_o | output | 1 | SCL held low by another device |
| done_o | output | 1 | One-cycle pulse when a START completes |
| status_o | output | 8 | 8'h08 after a successful START, else 8'hF8 |

## Verification
The START path is exercised on a free bus, on a bus made busy by another master and then freed by a STOP, and on a busy bus freed by a forced access. The first separates immediate issue from waiting. The other two separate a line-observed release from the self-cleared stop request, and the forced case must show no STOP on the lines. The slave model holds SDA for 0, 1, 2 and 3 SCL falls, which tells pair-wise retrying apart from retrying after every pulse through the count of extra pulses. It also runs this model under a repeated START, where SDA and SCL must be released in order. Directed cases cover a held SCL, a lone stop request, and the low-phase length for several half-period values.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_REL_SDA, ST_REL_SCL,
    ST_CHECK, ST_PULSE_LO, ST_PULSE_HI, ST_START
  } st_e;

  localparam logic [7:0] STAT_START_OK = 8'h08;
  localparam logic [7:0] STAT_NONE     = 8'hF8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], line_i};
  end

  assign line_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic force_free_i,
  output logic busy_o,
  output logic scl_rise_o
);
  logic scl_d_q, sda_d_q, busy_q;
  logic start_det, stop_det;

  assign start_det  = scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
  assign stop_det   = scl_s_i & scl_d_q & ~sda_d_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_d_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
      if (start_det)                  busy_q <= 1'b1;
      else if (stop_det || force_free_i) busy_q <= 1'b0;
    end
  end

  a_r2_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> busy_q);
  a_r2_free_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_q);
endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= half_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int STUCK_HALVES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  input  logic              sta_set_i,
  input  logic              sto_set_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              sta_o,
  output logic              sto_o,
  output logic              bus_busy_o,
  output logic              scl_stuck_o,
  output logic              done_o,
  output logic [7:0]        status_o
);
  localparam int STK_W = $clog2(STUCK_HALVES + 1);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_lines, syn_lines;
  logic scl_s, sda_s, scl_rise, busy;
  st_e  st_q, st_d;
  logic tmr_restart, tmr_exp, force_free, sto_clr, start_ok, stk_tick;
  logic sta_q, sto_q, own_q, pair_q, pair_d, done_q, waiting_hi;
  logic [STK_W-1:0] stk_q;
  logic [7:0] status_q;

  assign raw_lines = {sda_i, scl_i};
  for (genvar g = 0; g < NLINE; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .line_i(raw_lines[g]), .line_o(syn_lines[g]));
  end
  assign scl_s = syn_lines[0];
  assign sda_s = syn_lines[1];

  i2c_bus_monitor u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .force_free_i(force_free), .busy_o(busy), .scl_rise_o(scl_rise));

  i2c_half_timer #(.CNT_W(HALF_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(tmr_restart),
    .half_i(half_i), .expired_o(tmr_exp));

  assign waiting_hi = (st_q == ST_REL_SCL) || (st_q == ST_PULSE_HI);

  always_comb begin
    st_d        = st_q;
    pair_d      = pair_q;
    tmr_restart = 1'b0;
    force_free  = 1'b0;
    sto_clr     = 1'b0;
    start_ok    = 1'b0;
    stk_tick    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sta_q && (own_q || !busy)) begin
          st_d = ST_REL_SDA; tmr_restart = 1'b1;
        end else if (sta_q) begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!busy) begin
          st_d = ST_REL_SDA; tmr_restart = 1'b1;
        end else if (sto_q) begin
          // forced access: no STOP on the lines
          st_d = ST_REL_SDA; tmr_restart = 1'b1;
          force_free = 1'b1; sto_clr = 1'b1;
        end
      end
      ST_REL_SDA: if (tmr_exp) begin st_d = ST_REL_SCL; tmr_restart = 1'b1; end
      ST_REL_SCL, ST_PULSE_HI: begin
        if (!scl_s) begin
          if (tmr_exp) begin tmr_restart = 1'b1; stk_tick = 1'b1; end
        end else if (scl_rise) begin
          tmr_restart = 1'b1;
        end else if (tmr_exp) begin
          if (st_q == ST_REL_SCL || pair_q) begin
            st_d = ST_CHECK; pair_d = 1'b0;
          end else begin
            st_d = ST_PULSE_LO; tmr_restart = 1'b1; pair_d = 1'b1;
          end
        end
      end
      ST_CHECK: begin
        tmr_restart = 1'b1;
        pair_d      = 1'b0;
        st_d        = sda_s ? ST_START : ST_PULSE_LO;
      end
      ST_PULSE_LO: if (tmr_exp) begin st_d = ST_PULSE_HI; tmr_restart = 1'b1; end
      ST_START: if (tmr_exp) begin st_d = ST_IDLE; start_ok = 1'b1; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pair_q   <= 1'b0;
      sta_q    <= 1'b0;
      sto_q    <= 1'b0;
      own_q    <= 1'b0;
      done_q   <= 1'b0;
      stk_q    <= '0;
      status_q <= STAT_NONE;
    end else begin
      st_q   <= st_d;
      pair_q <= pair_d;
      done_q <= start_ok;
      if (start_ok)       sta_q <= 1'b0;
      else if (sta_set_i) sta_q <= 1'b1;
      if (sto_set_i)      sto_q <= 1'b1;
      else if (sto_clr)   sto_q <= 1'b0;
      if (start_ok) own_q <= 1'b1;
      if (start_ok)                   status_q <= STAT_START_OK;
      else if (sta_set_i && !sta_q)   status_q <= STAT_NONE;
      if (!waiting_hi || scl_s)       stk_q <= '0;
      else if (stk_tick && stk_q != STK_W'(STUCK_HALVES)) stk_q <= stk_q + 1'b1;
    end
  end

  assign scl_oe_o    = (own_q && (st_q == ST_IDLE || st_q == ST_WAIT || st_q == ST_REL_SDA))
                     || (st_q == ST_PULSE_LO);
  assign sda_oe_o    = (own_q && st_q == ST_IDLE) || (st_q == ST_START);
  assign sta_o       = sta_q;
  assign sto_o       = sto_q;
  assign bus_busy_o  = busy;
  assign scl_stuck_o = (stk_q == STK_W'(STUCK_HALVES));
  assign done_o      = done_q;
  assign status_o    = status_q;

  a_r3_sda_falls_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (scl_s && !scl_oe_o));
  a_r5_sto_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && busy && sto_q && !sto_set_i) |=> !sto_q);
  a_r6_retry_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHECK) |=> (st_q == ST_START || (st_q == ST_PULSE_LO && !pair_q)));
  a_r8_stuck_no_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_stuck_o |-> !sda_oe_o);
endmodule

// File: tb/i2c_start_ctrl_bench.sv
module i2c_start_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W     = 8;
  localparam int STUCK      = 3;

  typedef struct packed {
    logic [7:0] half;
    logic       busy;
    logic       force_acc;
    logic [3:0] stuck;
    logic       rep;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{8'd3, 1'b0, 1'b0, 4'd0, 1'b0},
    '{8'd5, 1'b0, 1'b0, 4'd1, 1'b0},
    '{8'd2, 1'b0, 1'b0, 4'd3, 1'b0},
    '{8'd4, 1'b1, 1'b1, 4'd0, 1'b0},
    '{8'd3, 1'b1, 1'b1, 4'd2, 1'b0},
    '{8'd3, 1'b0, 1'b0, 4'd1, 1'b1},
    '{8'd4, 1'b1, 1'b0, 4'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [HALF_W-1:0] half;
  logic sta_set, sto_set, ext_scl_low, ext_sda_low;
  logic scl_oe, sda_oe, sta, sto, busy, stuck, done;
  logic [7:0] status;
  logic scl_line, sda_line, slave_hold;
  int   falls_cnt, slave_base, slave_target;
  int   rises_tot, rise_at_start, stops_tot, run_len, first_len, base_rises;
  bit   bad_order;
  int   n_chk, n_err, cyc;
  logic p_scl, p_sda, p_scl_oe, p_sda_oe;

  assign slave_hold = (falls_cnt - slave_base) < slave_target;
  assign scl_line   = ~(scl_oe | ext_scl_low);
  assign sda_line   = ~(sda_oe | ext_sda_low | slave_hold);

  i2c_start_ctrl #(.HALF_W(HALF_W), .STUCK_HALVES(STUCK)) u_i2c_start_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .half_i(half), .sta_set_i(sta_set),
    .sto_set_i(sto_set), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sta_o(sta), .sto_o(sto),
    .bus_busy_o(busy), .scl_stuck_o(stuck), .done_o(done), .status_o(status));

  // line observer
  always @(negedge clk) begin
    cyc++;
    if (p_scl && !scl_line) falls_cnt++;
    if (p_scl && scl_line && !p_sda && sda_line) stops_tot++;
    if (!p_scl_oe && scl_oe) rises_tot++;
    if (scl_oe) run_len++;
    if (p_scl_oe && !scl_oe) begin
      if (rises_tot == base_rises + 1) first_len = run_len;
      run_len = 0;
    end
    if (!p_sda_oe && sda_oe) begin
      rise_at_start = rises_tot;
      if (!scl_line || scl_oe) bad_order = 1'b1;
    end
    p_scl = scl_line; p_sda = sda_line; p_scl_oe = scl_oe; p_sda_oe = sda_oe;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sta_set = 1'b0; sto_set = 1'b0;
    ext_scl_low = 1'b0; ext_sda_low = 1'b0; slave_target = 0;
    tick(3); rst_n = 1'b1; tick(3);
  endtask

  task automatic pulse_sta(); sta_set = 1'b1; tick(1); sta_set = 1'b0; endtask
  task automatic pulse_sto(); sto_set = 1'b1; tick(1); sto_set = 1'b0; endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    seen = 1'b0;
    while (t < 6000 && !seen) begin
      tick(1); t++;
      if (done) seen = 1'b1;
    end
  endtask

  // another master: START then SCL low, SDA high, SCL high (bus left busy)
  task automatic other_start();
    ext_sda_low = 1'b1; tick(10);
    ext_scl_low = 1'b1; tick(10);
    ext_sda_low = 1'b0; tick(10);
    ext_scl_low = 1'b0; tick(10);
  endtask

  task automatic arm_slave(input int n);
    ext_scl_low = 1'b1; tick(5);
    slave_base = falls_cnt; slave_target = n; tick(5);
    ext_scl_low = 1'b0; tick(10);
  endtask

  task automatic run_row(input row_t r, input int idx);
    bit seen;
    int exp_p, stops0;
    do_reset();
    half = r.half;
    if (r.rep) begin
      pulse_sta(); wait_done(seen);
      chk(seen, "R7 first START", seen, 1);
      tick(5);
      slave_base = falls_cnt; slave_target = r.stuck;
    end else begin
      if (r.busy) begin
        other_start();
        chk(busy == 1'b1, "R2 busy after START", busy, 1);
      end
      if (r.stuck != 0) arm_slave(r.stuck);
    end
    base_rises = rises_tot; first_len = -1; bad_order = 1'b0;
    rise_at_start = -1; stops0 = stops_tot;
    pulse_sta();
    if (r.busy) begin
      tick(30);
      chk(!scl_oe && !sda_oe, "R4 quiet while busy", {scl_oe, sda_oe}, 0);
      if (r.force_acc) begin
        pulse_sto(); tick(3);
        chk(sto == 1'b0, "R5 sto self-cleared", sto, 0);
      end else begin
        ext_sda_low = 1'b1; tick(10); ext_sda_low = 1'b0;
      end
    end
    wait_done(seen);
    chk(seen, "R3 done pulse", seen, 1);
    exp_p = 2 * ((int'(r.stuck) + 1) / 2);
    chk(rise_at_start - base_rises == exp_p, r.rep ? "R7 pulses" : "R6 pulses",
        rise_at_start - base_rises, exp_p);
    chk(!bad_order, "R3 SDA falls with SCL high", bad_order, 0);
    tick(1);
    chk(status == 8'h08 && !sta, "R3 status/sta", status, 8'h08);
    chk(scl_oe && sda_oe, "R3 lines held", {scl_oe, sda_oe}, 3);
    if (r.force_acc)
      chk(stops_tot == stops0, "R5 no STOP driven", stops_tot - stops0, 0);
    if (r.stuck != 0)
      chk(first_len == int'(r.half) + 1, "R10 low phase", first_len, int'(r.half) + 1);
    if (idx < 0) $display("row %0d", idx);
  endtask

  initial begin
    bit seen;
    n_chk = 0; n_err = 0; cyc = 0; falls_cnt = 0; slave_base = 0;
    rises_tot = 0; stops_tot = 0; run_len = 0;
    p_scl = 1'b1; p_sda = 1'b1; p_scl_oe = 1'b0; p_sda_oe = 1'b0;
    half = 8'd3;
    do_reset();
    // R1 reset state
    chk(!scl_oe && !sda_oe && !sta && !sto && !busy && !stuck && !done,
        "R1 reset outputs", {scl_oe, sda_oe, sta, sto, busy, stuck, done}, 0);
    chk(status == 8'hF8, "R1 reset status", status, 8'hF8);

    // R2 busy tracking
    ext_sda_low = 1'b1; tick(8);
    chk(busy == 1'b1, "R2 busy on START", busy, 1);
    ext_sda_low = 1'b0; tick(8);
    chk(busy == 1'b0, "R2 free on STOP", busy, 0);

    // main table
    for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

    // R9 stop alone
    do_reset();
    pulse_sto(); tick(40);
    chk(!scl_oe && !sda_oe, "R9 no drive", {scl_oe, sda_oe}, 0);
    chk(sto == 1'b1, "R9 sto kept", sto, 1);

    // R8 SCL held low
    do_reset();
    half = 8'd4;
    ext_scl_low = 1'b1; tick(5);
    pulse_sta(); tick(60);
    chk(stuck == 1'b1, "R8 stuck flag", stuck, 1);
    chk(!sda_oe && status == 8'hF8, "R8 no progress", {sda_oe, status}, 8'hF8);
    ext_scl_low = 1'b0; tick(6);
    chk(stuck == 1'b0, "R8 flag clears", stuck, 0);
    wait_done(seen);
    chk(seen && status == 8'h08, "R8 START after release", status, 8'h08);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule